// File: doc/BRIEF.md
# Protected Key Register Bank

This block holds the secret key and the initial-vector (counter) words for a block-cipher engine. Software reaches it through a simple word-wide register bus with separate write and read ports. The engine reads the live key and IV as wide parallel buses. The engine also reports when it is busy, can load a new counter value into the IV words, and supplies its feedback words so that software can read them back.

A control word sets the key length. The length is 128, 192 or 256 bits, which makes 4, 6 or 8 of the eight key words active. Separate option bits reverse the byte order of words that software writes into the key and IV registers, and of words that software reads from the key, IV and feedback registers. Once software sets the protect bit, reads of the key words return zero. The engine still sees the stored key. Protection can be removed only by a coded unlock write. That write also erases all eight key words in the same clock edge. While the engine is busy, key-length changes, unlock attempts and bus writes to the key and IV words are all held off.

Top module: `cipher_key_bank`

## Requirements
- R1: After a synchronous active-low reset, all key and IV words are zero, the control word reads 0 and protection is off.
- R2: Control bits [1:0] select the key length: 00 = 128 bits (words 0-3 active), 01 = 192 bits (words 0-5), 10 = 256 bits (words 0-7). On `key_out`, word i sits at bits [32i+31:32i], and inactive words read as zero. A write of 11 leaves the length unchanged.
- R3: With protection off and no byte reversal, a key word written at address 1+i (i = 0..7) reads back unchanged at the same address.
- R4: A control write (address 0) with bit 31 set turns protection on, even while busy. Control bit 31 reads back the protection state.
- R5: While protection is on, reads of key addresses 1..8 return zero. `key_out` still carries the stored key, and IV reads are unaffected.
- R6: A control write with bit 31 = 0 and bits [30:26] = 10110, made while not busy, turns protection off and zeroes all eight key words at the same clock edge. IV words are kept. Bit 31 = 0 with any other code changes nothing about protection or the key. Bits [30:26] read back the last accepted code.
- R7: While `engine_busy` is high, control writes do not change the key length or the code field and cannot unlock. Bus writes to key words (addresses 1..8) and IV words (addresses 9..12) are ignored.
- R8: When control bit 2 is set, each word written to a key or IV address is stored byte-reversed: {b3,b2,b1,b0} becomes {b0,b1,b2,b3}.
- R9: When control bit 3 is set, reads of key, IV and feedback addresses return the byte-reversed word. Control-word reads and the `key_out`/`iv_out` buses are not affected.
- R10: When `iv_upd_en` is high, all IV words load `iv_upd_data` at the next edge. This load wins over a bus IV write in the same cycle.
- R11: Addresses 13..16 read feedback words 0..3 from `fb_in`. Any address above 16 reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Read word address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| engine_busy | input | 1 | Cipher engine is processing |
| fb_in | input | 128 | Feedback words from the engine, word i at [32i+31:32i] |
| iv_upd_en | input | 1 | Engine loads a new counter/IV value |
| iv_upd_data | input | 128 | Counter/IV value to load |
| key_out | output | 256 | Active key words to the engine, inactive words zero |
| iv_out | output | 128 | IV/counter words to the engine |

## Verification
The assertions assume that the write port presents at most one access per cycle. They also assume that `engine_busy`, `iv_upd_en` and the write inputs are settled before each rising edge, so that an unlock attempt and a busy indication are sampled together. The stimulus changes every input only just after a falling edge and raises `engine_busy` only around the specific writes it means to block. It also drives a counter load in the same cycle as a bus IV write, so that the priority between them is actually exercised and not just assumed.

// File: rtl/kb_pkg.sv
// Package: shared constants and types for the protected key register bank.
// Assumes a 32-bit control word; the field positions below are fixed.
package kb_pkg;

    typedef enum logic [1:0] {
        KSZ_128  = 2'b00,
        KSZ_192  = 2'b01,
        KSZ_256  = 2'b10,
        KSZ_RSVD = 2'b11
    } ksz_e;

    localparam int CTL_SZ_LO   = 0;
    localparam int CTL_SZ_HI   = 1;
    localparam int CTL_ISW     = 2;
    localparam int CTL_OSW     = 3;
    localparam int CTL_CODE_LO = 26;
    localparam int CTL_CODE_HI = 30;
    localparam int CTL_PROT    = 31;
    localparam int CODE_W      = CTL_CODE_HI - CTL_CODE_LO + 1;

    localparam logic [CODE_W-1:0] UNLOCK_CODE = 5'b10110;

endpackage

// File: rtl/kb_byteswap.sv
// Module: reverses the byte order of one word.
// Assumes W is a multiple of 8. Pure wiring, no logic depth.
module kb_byteswap #(
    parameter int W = 32
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int NBYTES = W / 8;

    // Byte g of the output takes byte NBYTES-1-g of the input.
    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        assign dout[8*g +: 8] = din[8*(NBYTES-1-g) +: 8];
    end

endmodule

// File: rtl/kb_ctrl.sv
// Module: control word for the key bank. Holds key length, swap options,
// code field and protection flag, and produces the one-cycle wipe request.
// Assumes ctl_we is a single-cycle write strobe qualified by address 0.
module kb_ctrl
    import kb_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [WORD_W-1:0] wdata,
    input  logic              busy,
    output ksz_e              ksize,
    output logic              in_swap,
    output logic              out_swap,
    output logic [CODE_W-1:0] code,
    output logic              prot,
    output logic              wipe
);
    logic              size_ok;
    logic [CODE_W-1:0] code_in;
    logic              unlock_hit;

    // Decode the incoming control write: size legality and unlock match.
    always_comb begin
        code_in    = wdata[CTL_CODE_HI:CTL_CODE_LO];
        size_ok    = (ksz_e'(wdata[CTL_SZ_HI:CTL_SZ_LO]) != KSZ_RSVD);
        unlock_hit = ctl_we && !busy && !wdata[CTL_PROT] && (code_in == UNLOCK_CODE);
        wipe       = unlock_hit;
    end

    // Update control fields; busy gates length, code and unlock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ksize    <= KSZ_128;
            in_swap  <= 1'b0;
            out_swap <= 1'b0;
            code     <= '0;
            prot     <= 1'b0;
        end else if (ctl_we) begin
            if (!busy && size_ok) begin
                ksize <= ksz_e'(wdata[CTL_SZ_HI:CTL_SZ_LO]);
            end
            in_swap  <= wdata[CTL_ISW];
            out_swap <= wdata[CTL_OSW];
            if (!busy) begin
                code <= code_in;
            end
            if (wdata[CTL_PROT]) begin
                prot <= 1'b1;
            end else if (unlock_hit) begin
                prot <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/kb_store.sv
// Module: key and IV word storage. Key words clear together on wipe;
// IV words accept a full counter load from the engine with priority.
// Assumes wdata is already byte-ordered and the write enables are one-hot.
module kb_store #(
    parameter int WORD_W    = 32,
    parameter int KEY_WORDS = 8,
    parameter int IV_WORDS  = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [KEY_WORDS-1:0]         key_we,
    input  logic [IV_WORDS-1:0]          iv_we,
    input  logic [WORD_W-1:0]            wdata,
    input  logic                         busy,
    input  logic                         wipe,
    input  logic                         iv_upd_en,
    input  logic [IV_WORDS*WORD_W-1:0]   iv_upd_data,
    output logic [KEY_WORDS*WORD_W-1:0]  key_flat,
    output logic [IV_WORDS*WORD_W-1:0]   iv_flat
);

    for (genvar g = 0; g < KEY_WORDS; g++) begin : g_key
        logic [WORD_W-1:0] word_q;
        // Key word: reset, wipe, then a bus write when not busy.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (wipe) begin
                word_q <= '0;
            end else if (key_we[g] && !busy) begin
                word_q <= wdata;
            end
        end
        assign key_flat[g*WORD_W +: WORD_W] = word_q;
    end

    for (genvar g = 0; g < IV_WORDS; g++) begin : g_iv
        logic [WORD_W-1:0] word_q;
        // IV word: engine counter load has priority over a bus write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (iv_upd_en) begin
                word_q <= iv_upd_data[g*WORD_W +: WORD_W];
            end else if (iv_we[g] && !busy) begin
                word_q <= wdata;
            end
        end
        assign iv_flat[g*WORD_W +: WORD_W] = word_q;
    end

endmodule

// File: rtl/cipher_key_bank.sv
// Module: top of the protected key register bank. Decodes bus addresses,
// applies the byte-order options, masks inactive key words toward the
// engine and builds the read data with key read protection.
// Assumes WORD_W = 32 (control field positions), KEY_WORDS divisible by 4.
// Map: 0 control, 1.. key words, then IV words, then feedback words.
module cipher_key_bank
    import kb_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int KEY_WORDS = 8,
    parameter int IV_WORDS  = 4,
    parameter int FB_WORDS  = 4,
    parameter int ADDR_W    = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [WORD_W-1:0]             wr_data,
    input  logic [ADDR_W-1:0]             rd_addr,
    output logic [WORD_W-1:0]             rd_data,
    input  logic                          engine_busy,
    input  logic [FB_WORDS*WORD_W-1:0]    fb_in,
    input  logic                          iv_upd_en,
    input  logic [IV_WORDS*WORD_W-1:0]    iv_upd_data,
    output logic [KEY_WORDS*WORD_W-1:0]   key_out,
    output logic [IV_WORDS*WORD_W-1:0]    iv_out
);
    localparam int KEY_BASE = 1;
    localparam int IV_BASE  = KEY_BASE + KEY_WORDS;
    localparam int FB_BASE  = IV_BASE + IV_WORDS;
    localparam int KW_HALF  = KEY_WORDS / 2;
    localparam int KW_STEP  = KEY_WORDS / 4;

    ksz_e                        ksize_q;
    logic                        in_swap_q;
    logic                        out_swap_q;
    logic [CODE_W-1:0]           code_q;
    logic                        prot_q;
    logic                        wipe;
    logic                        ctl_we;
    logic [KEY_WORDS-1:0]        key_we;
    logic [IV_WORDS-1:0]         iv_we;
    logic [WORD_W-1:0]           wr_rev;
    logic [WORD_W-1:0]           wdata_st;
    logic [KEY_WORDS*WORD_W-1:0] key_flat;
    logic [IV_WORDS*WORD_W-1:0]  iv_flat;
    logic [WORD_W-1:0]           rd_raw;
    logic [WORD_W-1:0]           rd_rev;
    logic                        rd_is_data;
    logic [WORD_W-1:0]           ctl_val;

    // Write decode: control strobe and one enable per stored word.
    assign ctl_we = wr_en && (wr_addr == '0);
    for (genvar g = 0; g < KEY_WORDS; g++) begin : g_kdec
        assign key_we[g] = wr_en && (wr_addr == ADDR_W'(KEY_BASE + g));
    end
    for (genvar g = 0; g < IV_WORDS; g++) begin : g_idec
        assign iv_we[g] = wr_en && (wr_addr == ADDR_W'(IV_BASE + g));
    end

    kb_ctrl #(.WORD_W(WORD_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_we   (ctl_we),
        .wdata    (wr_data),
        .busy     (engine_busy),
        .ksize    (ksize_q),
        .in_swap  (in_swap_q),
        .out_swap (out_swap_q),
        .code     (code_q),
        .prot     (prot_q),
        .wipe     (wipe)
    );

    kb_byteswap #(.W(WORD_W)) u_inswap (
        .din  (wr_data),
        .dout (wr_rev)
    );

    assign wdata_st = in_swap_q ? wr_rev : wr_data;

    kb_store #(
        .WORD_W    (WORD_W),
        .KEY_WORDS (KEY_WORDS),
        .IV_WORDS  (IV_WORDS)
    ) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .key_we      (key_we),
        .iv_we       (iv_we),
        .wdata       (wdata_st),
        .busy        (engine_busy),
        .wipe        (wipe),
        .iv_upd_en   (iv_upd_en),
        .iv_upd_data (iv_upd_data),
        .key_flat    (key_flat),
        .iv_flat     (iv_flat)
    );

    // Engine key bus: words past the selected length are forced to zero.
    for (genvar g = 0; g < KEY_WORDS; g++) begin : g_kmask
        assign key_out[g*WORD_W +: WORD_W] =
            (g < KW_HALF + KW_STEP * int'(ksize_q)) ? key_flat[g*WORD_W +: WORD_W] : '0;
    end
    assign iv_out = iv_flat;

    // Control word read value.
    always_comb begin
        ctl_val                          = '0;
        ctl_val[CTL_SZ_HI:CTL_SZ_LO]     = ksize_q;
        ctl_val[CTL_ISW]                 = in_swap_q;
        ctl_val[CTL_OSW]                 = out_swap_q;
        ctl_val[CTL_CODE_HI:CTL_CODE_LO] = code_q;
        ctl_val[CTL_PROT]                = prot_q;
    end

    // Read select; key words are hidden while protected.
    always_comb begin
        rd_raw     = '0;
        rd_is_data = 1'b0;
        if (rd_addr == '0) begin
            rd_raw = ctl_val;
        end
        for (int i = 0; i < KEY_WORDS; i++) begin
            if (rd_addr == ADDR_W'(KEY_BASE + i)) begin
                rd_is_data = 1'b1;
                rd_raw     = prot_q ? '0 : key_flat[i*WORD_W +: WORD_W];
            end
        end
        for (int i = 0; i < IV_WORDS; i++) begin
            if (rd_addr == ADDR_W'(IV_BASE + i)) begin
                rd_is_data = 1'b1;
                rd_raw     = iv_flat[i*WORD_W +: WORD_W];
            end
        end
        for (int i = 0; i < FB_WORDS; i++) begin
            if (rd_addr == ADDR_W'(FB_BASE + i)) begin
                rd_is_data = 1'b1;
                rd_raw     = fb_in[i*WORD_W +: WORD_W];
            end
        end
    end

    kb_byteswap #(.W(WORD_W)) u_outswap (
        .din  (rd_raw),
        .dout (rd_rev)
    );

    assign rd_data = (rd_is_data && out_swap_q) ? rd_rev : rd_raw;

endmodule

// File: rtl/kb_chk.sv
// Module: property checker for cipher_key_bank, attached by bind below.
// Assumes one bus write per cycle and inputs settled before each edge.
module kb_chk
    import kb_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int KEY_WORDS = 8,
    parameter int IV_WORDS  = 4,
    parameter int ADDR_W    = 5
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          wr_en,
    input logic [ADDR_W-1:0]             wr_addr,
    input logic [WORD_W-1:0]             wr_data,
    input logic                          busy,
    input logic [ADDR_W-1:0]             rd_addr,
    input logic [WORD_W-1:0]             rd_data,
    input logic [KEY_WORDS*WORD_W-1:0]   key_out,
    input logic [IV_WORDS*WORD_W-1:0]    iv_out,
    input logic                          iv_upd_en,
    input logic [IV_WORDS*WORD_W-1:0]    iv_upd_data,
    input logic                          prot,
    input logic [1:0]                    ksize
);
    localparam int KEY_BASE = 1;
    localparam int KEY_END  = KEY_BASE + KEY_WORDS;

    logic ctl_wr;
    logic key_rd;
    assign ctl_wr = wr_en && (wr_addr == '0);
    assign key_rd = (int'(rd_addr) >= KEY_BASE) && (int'(rd_addr) < KEY_END);

    AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        ksize != 2'b11);  // R2

    AST_SHORT_KEY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ksize == 2'b00) |-> (key_out[KEY_WORDS*WORD_W-1:KEY_WORDS*WORD_W/2] == '0));  // R2

    AST_PROT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && wr_data[CTL_PROT]) |=> prot);  // R4

    AST_PROT_HIDES_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        (prot && key_rd) |-> (rd_data == '0));  // R5

    AST_UNLOCK_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !busy && !wr_data[CTL_PROT] && (wr_data[CTL_CODE_HI:CTL_CODE_LO] == UNLOCK_CODE))
        |=> (!prot && (key_out == '0)));  // R6

    AST_BUSY_SIZE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ctl_wr) |=> $stable(ksize));  // R7

    AST_BUSY_KEY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(key_out));  // R7

    AST_CTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        iv_upd_en |=> (iv_out == $past(iv_upd_data)));  // R10

endmodule

bind cipher_key_bank kb_chk #(
    .WORD_W    (WORD_W),
    .KEY_WORDS (KEY_WORDS),
    .IV_WORDS  (IV_WORDS),
    .ADDR_W    (ADDR_W)
) u_kb_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .busy        (engine_busy),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .key_out     (key_out),
    .iv_out      (iv_out),
    .iv_upd_en   (iv_upd_en),
    .iv_upd_data (iv_upd_data),
    .prot        (prot_q),
    .ksize       (ksize_q)
);

// File: tb/test_cipher_key_bank.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared on every clock, plus
// directed checks for each requirement.
module test_cipher_key_bank;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         wr_en;
    logic [4:0]   wr_addr;
    logic [31:0]  wr_data;
    logic [4:0]   rd_addr;
    logic [31:0]  rd_data;
    logic         engine_busy;
    logic [127:0] fb_in;
    logic         iv_upd_en;
    logic [127:0] iv_upd_data;
    logic [255:0] key_out;
    logic [127:0] iv_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // Reference state
    logic [31:0] m_key [8];
    logic [31:0] m_iv  [4];
    logic [1:0]  m_size;
    logic        m_isw, m_osw, m_prot;
    logic [4:0]  m_code;

    always #10 clk = ~clk;  // 50 MHz

    cipher_key_bank i_cipher_key_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .engine_busy(engine_busy), .fb_in(fb_in), .iv_upd_en(iv_upd_en),
        .iv_upd_data(iv_upd_data), .key_out(key_out), .iv_out(iv_out)
    );

    function automatic logic [31:0] rev32(input logic [31:0] x);
        return {x[7:0], x[15:8], x[23:16], x[31:24]};
    endfunction

    function automatic logic [31:0] exp_rd(input int a);
        logic [31:0] v;
        if (a == 0) return {m_prot, m_code, 22'd0, m_osw, m_isw, m_size};
        if (a >= 1 && a <= 8)        v = m_prot ? 32'd0 : m_key[a-1];
        else if (a >= 9 && a <= 12)  v = m_iv[a-9];
        else if (a >= 13 && a <= 16) v = fb_in[(a-13)*32 +: 32];
        else return 32'd0;
        return m_osw ? rev32(v) : v;
    endfunction

    function automatic logic [255:0] exp_key();
        logic [255:0] k = '0;
        for (int i = 0; i < 8; i++)
            if (i < 4 + 2*int'(m_size)) k[i*32 +: 32] = m_key[i];
        return k;
    endfunction

    function automatic logic [127:0] exp_iv();
        logic [127:0] v;
        for (int i = 0; i < 4; i++) v[i*32 +: 32] = m_iv[i];
        return v;
    endfunction

    function automatic string tag_of(input int a);
        if (a == 0) return "R4";
        if (a <= 8) return "R5";
        if (a <= 12) return "R8";
        return "R11";
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [255:0] act, input logic [255:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Reference update for one rising edge, using the inputs held across it.
    task automatic model_edge();
        int a = int'(wr_addr);
        logic [31:0] w;
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) m_key[i] = '0;
            for (int i = 0; i < 4; i++) m_iv[i] = '0;
            m_size = 2'b00; m_isw = 0; m_osw = 0; m_prot = 0; m_code = '0;
            return;
        end
        w = m_isw ? rev32(wr_data) : wr_data;
        if (wr_en) begin
            if (a == 0) begin
                if (!engine_busy && wr_data[1:0] != 2'b11) m_size = wr_data[1:0];
                if (!engine_busy) m_code = wr_data[30:26];
                if (wr_data[31]) m_prot = 1'b1;
                else if (!engine_busy && wr_data[30:26] == 5'b10110) begin
                    m_prot = 1'b0;
                    for (int i = 0; i < 8; i++) m_key[i] = '0;
                end
                m_isw = wr_data[2];
                m_osw = wr_data[3];
            end else if (a <= 8 && !engine_busy) m_key[a-1] = w;
            else if (a >= 9 && a <= 12 && !engine_busy) m_iv[a-9] = w;
        end
        if (iv_upd_en)
            for (int i = 0; i < 4; i++) m_iv[i] = iv_upd_data[i*32 +: 32];
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        #1;
        check(tag_of(int'(rd_addr)), "per-cycle rd_data", 256'(rd_data), 256'(exp_rd(int'(rd_addr))));
        check("R2", "per-cycle key_out", key_out, exp_key());
        check("R10", "per-cycle iv_out", 256'(iv_out), 256'(exp_iv()));
    endtask

    task automatic bus_wr(input int a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = 5'(a); wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input int a, input logic [31:0] exp, input string tag, input string what);
        rd_addr = 5'(a);
        #1;
        check(tag, what, 256'(rd_data), 256'(exp));
    endtask

    initial begin
        #(20ns * 200000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 0; wr_en = 0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        engine_busy = 0; fb_in = '0; iv_upd_en = 0; iv_upd_data = '0;
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R1 reset state
        rd_chk(0, 32'h0, "R1", "control after reset");
        rd_chk(1, 32'h0, "R1", "key0 after reset");
        check("R1", "key_out after reset", key_out, '0);
        check("R1", "iv_out after reset", 256'(iv_out), '0);

        // R3 key writes, R2 length selection
        bus_wr(0, 32'h0000_0002);
        for (int i = 0; i < 8; i++) bus_wr(1 + i, 32'h1000_0000 * (i + 1) + i);
        rd_chk(4, 32'h4000_0003, "R3", "key3 readback");
        rd_chk(8, 32'h8000_0007, "R3", "key7 readback");
        check("R2", "256-bit top word", 256'(key_out[255:224]), 256'(32'h8000_0007));
        bus_wr(0, 32'h0000_0000);
        check("R2", "128-bit upper half zero", 256'(key_out[255:128]), '0);
        check("R2", "128-bit word3", 256'(key_out[127:96]), 256'(32'h4000_0003));
        bus_wr(0, 32'h0000_0001);
        check("R2", "192-bit word5", 256'(key_out[191:160]), 256'(32'h6000_0005));
        check("R2", "192-bit words 6-7 zero", 256'(key_out[255:192]), '0);
        bus_wr(0, 32'h0000_0003);
        rd_chk(0, 32'h0000_0001, "R2", "reserved length ignored");

        // R8 input byte reversal
        bus_wr(0, 32'h0000_0006);
        bus_wr(1, 32'h1122_3344);
        bus_wr(10, 32'hA1B2_C3D4);
        rd_chk(1, 32'h4433_2211, "R8", "key0 stored reversed");
        rd_chk(10, 32'hD4C3_B2A1, "R8", "iv1 stored reversed");

        // R9 output byte reversal
        bus_wr(0, 32'h0000_000A);
        fb_in[95:64] = 32'hDEAD_BEEF;
        rd_chk(1, 32'h1122_3344, "R9", "key0 read reversed");
        rd_chk(15, 32'hEFBE_ADDE, "R9", "feedback2 read reversed");
        rd_chk(0, 32'h0000_000A, "R9", "control not reversed");
        check("R9", "key_out not reversed", 256'(key_out[31:0]), 256'(32'h4433_2211));

        // R4/R5 protection
        bus_wr(0, 32'h8000_0002);
        rd_chk(0, 32'h8000_0002, "R4", "protect flag readback");
        rd_chk(2, 32'h0, "R5", "protected key1 read");
        check("R5", "engine still sees key1", 256'(key_out[63:32]), 256'(32'h2000_0001));
        rd_chk(10, 32'hD4C3_B2A1, "R5", "iv readable while protected");

        // R6 wrong code keeps protection
        bus_wr(0, 32'h5400_0002);
        rd_chk(0, 32'hD400_0002, "R6", "wrong code keeps protect");
        check("R6", "wrong code keeps key", 256'(key_out[63:32]), 256'(32'h2000_0001));

        // R7 busy gating
        engine_busy = 1;
        bus_wr(0, 32'h5800_0000);
        rd_chk(0, 32'hD400_0002, "R7", "unlock/size/code blocked while busy");
        bus_wr(2, 32'hFFFF_FFFF);
        check("R7", "key write blocked while busy", 256'(key_out[63:32]), 256'(32'h2000_0001));
        bus_wr(9, 32'h1234_5678);
        check("R7", "iv write blocked while busy", 256'(iv_out[31:0]), '0);
        engine_busy = 0;

        // R6 unlock wipes key, keeps IV
        bus_wr(0, 32'h5800_0002);
        rd_chk(0, 32'h5800_0002, "R6", "unlock clears protect");
        check("R6", "unlock wipes key", key_out, '0);
        rd_chk(8, 32'h0, "R6", "key7 wiped");
        check("R6", "iv kept on unlock", 256'(iv_out[63:32]), 256'(32'hD4C3_B2A1));

        // R4 protect accepted while busy
        engine_busy = 1;
        bus_wr(0, 32'h8000_0002);
        rd_chk(0, 32'hD800_0002, "R4", "protect set while busy");
        engine_busy = 0;
        bus_wr(0, 32'h5800_0002);

        // R3 write after unlock
        bus_wr(4, 32'hCAFE_F00D);
        rd_chk(4, 32'hCAFE_F00D, "R3", "key3 after unlock");

        // R10 counter load beats bus write
        iv_upd_en = 1;
        iv_upd_data = 128'h0000_0004_0000_0003_0000_0002_0000_0001;
        bus_wr(9, 32'h5555_AAAA);
        iv_upd_en = 0;
        check("R10", "counter load over bus write", 256'(iv_out), 256'(128'h0000_0004_0000_0003_0000_0002_0000_0001));
        rd_chk(9, 32'h0000_0001, "R10", "iv0 after counter load");

        // R11 feedback and unmapped reads
        fb_in[31:0] = 32'h0BAD_F00D;
        rd_chk(13, 32'h0BAD_F00D, "R11", "feedback0 read");
        rd_chk(20, 32'h0, "R11", "unmapped address");
        rd_chk(31, 32'h0, "R11", "top address");
        tick();

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule